// File: doc/BRIEF.md
# Multi-core event wake aggregator

This block gathers send-event requests from a group of processor cores and turns them into one wake event that goes back to every core. Each core raises its request for a few cycles of a fast core clock. The block itself runs on a slower platform clock. A short pulse from a fast core can fall between two platform edges, so every request is first caught in a sticky flag in the core domain. That flag is handed across to the platform domain with a four-phase handshake, and it drops only after the platform side has seen it.

Any captured request is ORed with the output of a programmable periodic timer, and the result is registered and driven to all cores. The timer fires once every N platform cycles. It has an enable bit and an interval value, and both are set through a small write port in the platform domain. Because of the timer, a core waiting for an event always wakes within a bounded time, even if some request had been lost.

The parameter `STRETCH` selects the capture variant. Setting it to zero replaces the sticky handshake with plain two-flop sampling of the request. The default is the sticky handshake.

Top module: `evt_wake_hub`

## Requirements
- R1: While `plat_rst` is high, and afterwards until something causes an event, `wake_evt` is all zeros. The periodic timer starts disabled and its interval starts at zero.
- R2: A rising edge on any `core_sev` bit, held for three core cycles, produces a wake event within 24 platform cycles. This holds at every core-to-platform clock ratio, including ratios above 3.
- R3: All bits of `wake_evt` carry the same value in every cycle.
- R4: Each captured request produces exactly one wake event, and that event is one platform cycle wide.
- R5: With the enable bit set and an interval N ≥ 1, the periodic timer drives `wake_evt` high in platform cycle e+N+1 after the write edge e that enabled it, and then every N cycles. With N = 1 the output stays high.
- R6: While the enable bit is clear, the periodic timer produces no wake events.
- R7: An interval of 0 produces no periodic wake events, even with the enable bit set.
- R8: Writing a new interval while the timer runs discards the count in progress. The next event comes N+1 cycles after the write edge, and no event left over from the old count appears.
- R9: Write map: address 0 is control, where bit 0 is the periodic enable. Address 1 is the interval, and it takes all `CNT_W` bits. Writes to addresses 2 and 3 change nothing, and they do not restart the count.
- R10: Requests raised by several cores in the same cycle are merged into one wake event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| core_clk | input | 1 | Core clock shared by all request sources |
| core_rst | input | 1 | Synchronous active-high reset, core domain |
| core_sev | input | NCORE | Send-event request, one bit per core |
| plat_clk | input | 1 | Platform clock |
| plat_rst | input | 1 | Synchronous active-high reset, platform domain |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | CNT_W | Register write data |
| wake_evt | output | NCORE | Wake event broadcast to every core |

## Verification
Requests are sent from each core alone, from two cores at once and from all cores at once. Each pattern is repeated at core-to-platform ratios of 1, 2.5, 4 and 5. The single-core pulses show whether a pulse shorter than one platform cycle survives the crossing. The combined pulses show whether simultaneous requests merge into one event rather than several. The periodic timer is run with intervals 1, 2, 5 and 37 against exact expected cycle numbers. A mid-count interval rewrite tells a proper reload apart from a stale tick. Writes to unmapped addresses, an interval of zero, and a cleared enable must each leave the output silent or the tick schedule unchanged.

// File: rtl/evt_wake_pkg.sv
package evt_wake_pkg;
  localparam int unsigned REG_ADDR_W = 2;

  typedef enum logic [REG_ADDR_W-1:0] {
    REG_CTRL   = 2'd0,
    REG_PERIOD = 2'd1
  } reg_sel_e;

  localparam int unsigned CTRL_EN_BIT = 0;
endpackage

// File: rtl/evt_sev_capture.sv
// One core's request path: edge capture and a sticky flag in the core domain,
// a synchronizer and edge detect in the platform domain.
module evt_sev_capture #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          STRETCH     = 1'b1
) (
  input  logic core_clk,
  input  logic core_rst,
  input  logic plat_clk,
  input  logic plat_rst,
  input  logic sev_i,
  output logic req_o,
  output logic ack_o,
  output logic rise_o
);
  localparam int unsigned MSB = SYNC_STAGES - 1;

  logic             req_q;
  logic [MSB:0]     req_sync_q;
  logic             req_seen_q;

  // platform side: synchronize the flag, remember the last level seen
  always_ff @(posedge plat_clk) begin
    if (plat_rst) begin
      req_sync_q <= '0;
      req_seen_q <= 1'b0;
    end else begin
      req_sync_q <= {req_sync_q[MSB-1:0], req_q};
      req_seen_q <= req_sync_q[MSB];
    end
  end

  assign rise_o = req_sync_q[MSB] & ~req_seen_q;
  assign req_o  = req_q;

  generate
    if (STRETCH) begin : g_stretch
      logic         sev_d_q;
      logic         pend_q;
      logic [MSB:0] ack_sync_q;
      logic         ack_s;
      logic         sev_rise;
      logic         launch;

      assign ack_s    = ack_sync_q[MSB];
      assign sev_rise = sev_i & ~sev_d_q;
      // a new flag goes out only once the previous handshake fully closed
      assign launch   = (pend_q | sev_rise) & ~req_q & ~ack_s;

      always_ff @(posedge core_clk) begin
        if (core_rst) begin
          sev_d_q    <= 1'b0;
          pend_q     <= 1'b0;
          ack_sync_q <= '0;
          req_q      <= 1'b0;
        end else begin
          sev_d_q    <= sev_i;
          ack_sync_q <= {ack_sync_q[MSB-1:0], req_seen_q};
          pend_q     <= (pend_q | sev_rise) & ~launch;
          if (launch)     req_q <= 1'b1;
          else if (ack_s) req_q <= 1'b0;
        end
      end

      assign ack_o = ack_s;
    end else begin : g_direct
      always_ff @(posedge core_clk) begin
        if (core_rst) req_q <= 1'b0;
        else          req_q <= sev_i;
      end
      assign ack_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/evt_wake_regs.sv
module evt_wake_regs
  import evt_wake_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic                  plat_clk,
  input  logic                  plat_rst,
  input  logic                  wr_en_i,
  input  logic [REG_ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]      wr_data_i,
  output logic                  en_o,
  output logic [CNT_W-1:0]      period_o,
  output logic                  reload_o
);
  logic             en_q;
  logic [CNT_W-1:0] period_q;
  logic             reload_q;
  logic             hit_ctrl;
  logic             hit_period;

  assign hit_ctrl   = wr_en_i && (wr_addr_i == REG_CTRL);
  assign hit_period = wr_en_i && (wr_addr_i == REG_PERIOD);

  always_ff @(posedge plat_clk) begin
    if (plat_rst) begin
      en_q     <= 1'b0;
      period_q <= '0;
      reload_q <= 1'b0;
    end else begin
      if (hit_ctrl)   en_q     <= wr_data_i[CTRL_EN_BIT];
      if (hit_period) period_q <= wr_data_i;
      reload_q <= hit_ctrl | hit_period;
    end
  end

  assign en_o     = en_q;
  assign period_o = period_q;
  assign reload_o = reload_q;
endmodule

// File: rtl/evt_period_timer.sv
module evt_period_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             plat_clk,
  input  logic             plat_rst,
  input  logic             en_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic             reload_i,
  output logic             tick_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             active;

  assign active = en_i && (period_i != '0);

  always_ff @(posedge plat_clk) begin
    if (plat_rst)                 cnt_q <= '0;
    else if (reload_i || !active) cnt_q <= period_i;
    else if (cnt_q == ONE)        cnt_q <= period_i;
    else                          cnt_q <= cnt_q - ONE;
  end

  // a pending reload masks a tick left over from the old count
  assign tick_o = active && !reload_i && (cnt_q == ONE);
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/evt_wake_hub.sv
module evt_wake_hub
  import evt_wake_pkg::*;
#(
  parameter int unsigned NCORE       = 4,
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          STRETCH     = 1'b1
) (
  input  logic                  core_clk,
  input  logic                  core_rst,
  input  logic [NCORE-1:0]      core_sev,
  input  logic                  plat_clk,
  input  logic                  plat_rst,
  input  logic                  wr_en,
  input  logic [REG_ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]      wr_data,
  output logic [NCORE-1:0]      wake_evt
);
  logic [NCORE-1:0] req_vec;
  logic [NCORE-1:0] ack_vec;
  logic [NCORE-1:0] rise_vec;
  logic             en_q;
  logic [CNT_W-1:0] period_q;
  logic             reload_q;
  logic             tick;
  logic [CNT_W-1:0] cnt;
  logic             wake_q;

  for (genvar i = 0; i < NCORE; i++) begin : g_core
    evt_sev_capture #(
      .SYNC_STAGES(SYNC_STAGES),
      .STRETCH    (STRETCH)
    ) i_cap (
      .core_clk(core_clk),
      .core_rst(core_rst),
      .plat_clk(plat_clk),
      .plat_rst(plat_rst),
      .sev_i   (core_sev[i]),
      .req_o   (req_vec[i]),
      .ack_o   (ack_vec[i]),
      .rise_o  (rise_vec[i])
    );
  end

  evt_wake_regs #(.CNT_W(CNT_W)) i_regs (
    .plat_clk (plat_clk),
    .plat_rst (plat_rst),
    .wr_en_i  (wr_en),
    .wr_addr_i(wr_addr),
    .wr_data_i(wr_data),
    .en_o     (en_q),
    .period_o (period_q),
    .reload_o (reload_q)
  );

  evt_period_timer #(.CNT_W(CNT_W)) i_timer (
    .plat_clk(plat_clk),
    .plat_rst(plat_rst),
    .en_i    (en_q),
    .period_i(period_q),
    .reload_i(reload_q),
    .tick_o  (tick),
    .cnt_o   (cnt)
  );

  always_ff @(posedge plat_clk) begin
    if (plat_rst) wake_q <= 1'b0;
    else          wake_q <= tick | (|rise_vec);
  end

  assign wake_evt = {NCORE{wake_q}};
endmodule

// File: rtl/evt_wake_hub_chk.sv
module evt_wake_hub_chk #(
  parameter int unsigned NCORE   = 4,
  parameter int unsigned CNT_W   = 16,
  parameter bit          STRETCH = 1'b1
) (
  input logic             core_clk,
  input logic             core_rst,
  input logic             plat_clk,
  input logic             plat_rst,
  input logic [NCORE-1:0] req_vec,
  input logic [NCORE-1:0] ack_vec,
  input logic [NCORE-1:0] rise_vec,
  input logic             en_q,
  input logic [CNT_W-1:0] period_q,
  input logic             reload_q,
  input logic             tick,
  input logic [CNT_W-1:0] cnt,
  input logic             wake_q
);
  // R4: every wake cycle traces back to a tick or a captured request
  assert_wake_cause_R4: assert property (@(posedge plat_clk) disable iff (plat_rst)
    wake_q |-> $past(tick || (|rise_vec)));

  // R6: no enable and no request in the previous cycle means silence
  assert_gate_off_R6: assert property (@(posedge plat_clk) disable iff (plat_rst)
    (!$past(en_q) && !$past(|rise_vec)) |-> !wake_q);

  // R7: a zero interval never ticks
  assert_zero_interval_R7: assert property (@(posedge plat_clk) disable iff (plat_rst)
    (($past(period_q) == '0) && !$past(|rise_vec)) |-> !wake_q);

  // R5: a running counter stays within 1..N
  assert_cnt_range_R5: assert property (@(posedge plat_clk) disable iff (plat_rst)
    (en_q && (period_q != '0) && !reload_q) |-> ((cnt != '0) && (cnt <= period_q)));

  generate
    if (STRETCH) begin : g_hold
      // R2: a sticky request drops only after the platform acknowledged it
      assert_req_hold_R2: assert property (@(posedge core_clk) disable iff (core_rst)
        ((~req_vec & $past(req_vec & ~ack_vec)) == '0));
    end
  endgenerate
endmodule

bind evt_wake_hub evt_wake_hub_chk #(
  .NCORE  (NCORE),
  .CNT_W  (CNT_W),
  .STRETCH(STRETCH)
) i_chk (
  .core_clk(core_clk),
  .core_rst(core_rst),
  .plat_clk(plat_clk),
  .plat_rst(plat_rst),
  .req_vec (req_vec),
  .ack_vec (ack_vec),
  .rise_vec(rise_vec),
  .en_q    (en_q),
  .period_q(period_q),
  .reload_q(reload_q),
  .tick    (tick),
  .cnt     (cnt),
  .wake_q  (wake_q)
);

// File: tb/test_evt_wake_hub.sv
module test_evt_wake_hub;
  timeunit 1ns;
  timeprecision 100ps;
  import evt_wake_pkg::*;

  localparam int  NCORE       = 4;
  localparam int  CNT_W       = 16;
  localparam real PLAT_PERIOD = 10.0;
  localparam int  WATCHDOG    = 20000;

  logic             core_clk = 1'b0;
  logic             plat_clk = 1'b0;
  logic             core_rst = 1'b1;
  logic             plat_rst = 1'b1;
  logic [NCORE-1:0] core_sev = '0;
  logic             wr_en    = 1'b0;
  logic [1:0]       wr_addr  = '0;
  logic [CNT_W-1:0] wr_data  = '0;
  logic [NCORE-1:0] wake_evt;

  real core_half = 5.0;
  real halves [4] = '{5.0, 2.0, 1.25, 1.0};

  always #(PLAT_PERIOD / 2.0) plat_clk = ~plat_clk;
  always #(core_half) core_clk = ~core_clk;

  evt_wake_hub #(.NCORE(NCORE), .CNT_W(CNT_W)) i_evt_wake_hub (
    .core_clk(core_clk), .core_rst(core_rst), .core_sev(core_sev),
    .plat_clk(plat_clk), .plat_rst(plat_rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wake_evt(wake_evt)
  );

  int cyc = 0;
  always @(posedge plat_clk) cyc <= cyc + 1;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef enum {M_IDLE, M_SEV, M_TICK} mode_e;
  mode_e mode = M_IDLE;
  int    sev_q [$];
  int    tick_q [$];
  int    stray = 0;
  logic  prev_wake = 1'b0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor: scoreboard pops on each observed wake cycle
  always @(negedge plat_clk) begin
    if (!plat_rst) begin
      if (wake_evt[0]) begin
        check(wake_evt == {NCORE{1'b1}}, "R3", "broadcast vector", int'(wake_evt), (1 << NCORE) - 1);
        case (mode)
          M_SEV: begin
            if (sev_q.size() > 0) begin
              void'(sev_q.pop_front());
              check(!prev_wake, "R4", "wake preceded by low cycle", int'(prev_wake), 0);
            end else stray++;
          end
          M_TICK: begin
            if (tick_q.size() > 0) begin
              int e;
              e = tick_q.pop_front();
              check(cyc == e, "R5", "tick cycle", cyc, e);
            end else stray++;
          end
          default: ;
        endcase
      end
      prev_wake = wake_evt[0];
    end
  end

  task automatic write_reg(int addr, int data, output int edge_no);
    @(negedge plat_clk);
    wr_en   = 1'b1;
    wr_addr = 2'(addr);
    wr_data = CNT_W'(data);
    @(posedge plat_clk);
    #1 edge_no = cyc;
    @(negedge plat_clk);
    wr_en = 1'b0;
  endtask

  task automatic sev_trial(logic [NCORE-1:0] mask, string req, int ratio_idx);
    sev_q.push_back(1);
    @(posedge core_clk);
    core_sev <= mask;
    repeat (3) @(posedge core_clk);
    core_sev <= '0;
    repeat (24) @(negedge plat_clk);
    check(sev_q.size() == 0, req, $sformatf("undelivered request, ratio index %0d", ratio_idx),
          sev_q.size(), 0);
    sev_q.delete();
  endtask

  task automatic drain_ticks(string req);
    int e;
    for (int g = 0; g < 2000 && tick_q.size() > 0; g++) @(posedge plat_clk);
    #1;
    check(tick_q.size() == 0, req, "ticks not seen", tick_q.size(), 0);
    mode = M_IDLE;
    tick_q.delete();
    write_reg(REG_CTRL, 0, e);
    repeat (4) @(negedge plat_clk);
    check(stray == 0, req, "unexpected wake cycles", stray, 0);
    stray = 0;
  endtask

  task automatic run_period(int n, int reps, string req);
    int e0;
    write_reg(REG_CTRL, 0, e0);
    write_reg(REG_PERIOD, n, e0);
    mode = M_TICK;
    write_reg(REG_CTRL, 1, e0);
    for (int k = 0; k < reps; k++) tick_q.push_back(e0 + n + 1 + k * n);
    drain_ticks(req);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge plat_clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d cycles", WATCHDOG, 0);
    finish_up();
  end

  initial begin
    int e0;
    int e1;
    // R1: reset state
    repeat (4) @(negedge plat_clk);
    check(wake_evt == '0, "R1", "wake during reset", int'(wake_evt), 0);
    core_rst = 1'b0;
    plat_rst = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge plat_clk);
      check(wake_evt == '0, "R1", "wake after reset", int'(wake_evt), 0);
    end

    // R2, R4, R10: requests at several clock ratios
    for (int r = 0; r < 4; r++) begin
      core_half = halves[r];
      repeat (4) @(negedge plat_clk);
      mode = M_SEV;
      for (int c = 0; c < NCORE; c++) sev_trial(NCORE'(1) << c, "R2", r);
      sev_trial(NCORE'(4'b0101), "R10", r);
      sev_trial({NCORE{1'b1}}, "R10", r);
      mode = M_IDLE;
      check(stray == 0, "R4", "duplicate wake cycles", stray, 0);
      stray = 0;
    end
    core_half = 5.0;

    // R5: exact periodic schedule
    run_period(5, 4, "R5");
    run_period(1, 6, "R5");
    run_period(2, 4, "R5");
    run_period(37, 3, "R5");

    // R6: interval set, enable clear
    write_reg(REG_PERIOD, 3, e0);
    write_reg(REG_CTRL, 0, e0);
    mode = M_TICK;
    repeat (40) @(negedge plat_clk);
    check(stray == 0, "R6", "wake while disabled", stray, 0);
    mode = M_IDLE;
    stray = 0;

    // R7: enable set, interval zero
    write_reg(REG_PERIOD, 0, e0);
    mode = M_TICK;
    write_reg(REG_CTRL, 1, e0);
    repeat (40) @(negedge plat_clk);
    check(stray == 0, "R7", "wake with zero interval", stray, 0);
    mode = M_IDLE;
    stray = 0;
    write_reg(REG_CTRL, 0, e0);

    // R8: rewrite the interval mid-count
    write_reg(REG_PERIOD, 6, e0);
    mode = M_TICK;
    write_reg(REG_CTRL, 1, e0);
    tick_q.push_back(e0 + 7);
    for (int g = 0; g < 200 && tick_q.size() > 0; g++) @(posedge plat_clk);
    #1;
    write_reg(REG_PERIOD, 4, e1);
    check(e1 <= e0 + 11, "R8", "rewrite edge too late", e1, e0 + 11);
    tick_q.push_back(e1 + 5);
    tick_q.push_back(e1 + 9);
    tick_q.push_back(e1 + 13);
    drain_ticks("R8");

    // R9: unmapped addresses change nothing
    write_reg(REG_PERIOD, 5, e0);
    mode = M_TICK;
    write_reg(REG_CTRL, 1, e0);
    for (int k = 0; k < 4; k++) tick_q.push_back(e0 + 6 + k * 5);
    write_reg(2, 0, e1);
    write_reg(3, 0, e1);
    drain_ticks("R9");

    finish_up();
  end
endmodule